// File: doc/BRIEF.md
# DMA Peripheral Request Source Selector

This block sits in front of one DMA channel and decides which on-chip peripheral request starts that channel's transfers. A 4-bit select code chooses one of eight request lines. Four lines come from two serial channels, each with a receive-full request and a transmit-empty request. The other four are the capture/compare-match requests of four timer channels. Each raw request is qualified by that peripheral's interrupt enable. The qualified line is also passed on, unchanged, toward the CPU interrupt path.

The select code limits what the channel may do. A serial receive request requires the matching receive data register as the transfer source. A serial transmit request requires the matching transmit data register as the destination. Serial requests also allow only single-transfer (cycle-steal) operation. Timer requests allow any permitted target at either end and either bus mode. The channel's own control registers are never a permitted target. When the programmed source, destination and bus mode conflict with the chosen request, a configuration-error flag rises and no trigger is produced.

Rising edges of the selected request are turned into a transfer trigger. In cycle-steal mode, each edge produces one trigger that is held until acknowledged. In burst mode, the trigger is held until the transfer count reaches zero. One extra request arriving while a trigger is outstanding is remembered.

Top module: `dma_req_select`

## Requirements
- R1: Select codes 4 to 11 route request line (code − 4) to the channel. Line order: bit 0 serial 0 receive, bit 1 serial 0 transmit, bit 2 serial 1 receive, bit 3 serial 1 transmit, bits 4 to 7 timers 0 to 3. Any other code selects nothing: the trigger stays low and the error flag is low. Edges on unselected lines never trigger.
- R2: A request line counts only when its interrupt-enable bit is set. `cpu_irq` equals `periph_req & periph_irq_en` in the same cycle.
- R3: Target codes are 0 external memory, 1 memory-mapped device, 2 on-chip memory, 3 other on-chip peripheral, 4 DMA control registers, 5 serial 0 receive data, 6 serial 0 transmit data, 7 serial 1 receive data, and 8 serial 1 transmit data. Codes 9 to 15 are unused. A permitted target is any code from 0 to 8 other than 4.
- R4: With a serial receive code (4 or 6) selected, `cfg_err` is high unless the source equals that channel's receive data code (5 or 7) and the destination is permitted.
- R5: With a serial transmit code (5 or 7) selected, `cfg_err` is high unless the destination equals that channel's transmit data code (6 or 8) and the source is permitted.
- R6: A serial select code with `burst_mode`=1 raises `cfg_err`. A timer select code (8 to 11) raises `cfg_err` only when the source or destination is not permitted, in either bus mode.
- R7: While `cfg_err` is high or `chan_en` is low, `xfer_trig` is low one cycle later and any remembered request is discarded.
- R8: In cycle-steal mode, a rising edge of the selected qualified request raises `xfer_trig` one cycle later. The trigger stays high until `xfer_ack` is sampled high, and is low in the following cycle.
- R9: A request edge arriving while the trigger is high is remembered. After the trigger falls, the trigger is low for exactly one cycle and then high again.
- R10: In burst mode, the trigger stays high until `count_zero` is sampled high, and `xfer_ack` has no effect on it.
- R11: A change of `res_sel` while `chan_en` is high discards a remembered request. The trigger then stays low after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| res_sel | input | 4 | Request source select code |
| src_tgt | input | 4 | Source target class code |
| dst_tgt | input | 4 | Destination target class code |
| burst_mode | input | 1 | 1 burst, 0 cycle-steal |
| periph_req | input | 8 | Raw peripheral request lines |
| periph_irq_en | input | 8 | Per-line interrupt enables |
| xfer_ack | input | 1 | Single-transfer acknowledge |
| count_zero | input | 1 | Transfer count has reached zero |
| cpu_irq | output | 8 | Qualified requests toward the interrupt path |
| xfer_trig | output | 1 | Transfer trigger |
| cfg_err | output | 1 | Configuration conflict flag |

## Verification
`cfg_err` and `cpu_irq` are combinational. They are checked 1 ns after the inputs change, with no clock edge in between. This lets the error rule be swept over every select code, target pair and bus mode. `xfer_trig` is registered: a request edge that is present at clock edge N shows on the trigger just after edge N. Acknowledge, count-zero and error conditions take effect at that same edge. The bench drives and samples 2 ns after each rising edge, so every sample reflects exactly one edge. The re-issue of a remembered request is checked as a low cycle after the fall, followed by a high cycle at the next edge.

// File: rtl/dmasel_pkg.sv
package dmasel_pkg;

    localparam int SEL_W        = 4;
    localparam int NUM_SERIAL   = 2;
    localparam int NUM_TIMER    = 4;
    localparam int SER_BASE     = 4;
    localparam int TIMER_BASE   = SER_BASE + 2 * NUM_SERIAL;
    localparam int NUM_LINES    = 2 * NUM_SERIAL + NUM_TIMER;
    localparam int LINE_W       = $clog2(NUM_LINES);
    localparam int TGT_W        = 4;
    localparam int TGT_DMAC     = 4;
    localparam int TGT_REG_BASE = 5;
    localparam int TGT_LIMIT    = TGT_REG_BASE + 2 * NUM_SERIAL;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_SER_RX,
        RK_SER_TX,
        RK_TIMER
    } req_kind_e;

    typedef struct packed {
        logic              valid;
        req_kind_e         kind;
        logic [LINE_W-1:0] line;
        logic [TGT_W-1:0]  fixed_reg;
    } route_t;

    function automatic logic tgt_permitted(input logic [TGT_W-1:0] t);
        return (int'(t) != TGT_DMAC) && (int'(t) < TGT_LIMIT);
    endfunction

endpackage

// File: rtl/dmasel_decode.sv
module dmasel_decode
    import dmasel_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output route_t           route
);
    always_comb begin
        int s;
        int off;
        s     = int'(sel);
        off   = s - SER_BASE;
        route = '{valid: 1'b0, kind: RK_NONE, line: '0, fixed_reg: '0};
        if (s >= SER_BASE && s < TIMER_BASE) begin
            route.valid     = 1'b1;
            route.kind      = ((off % 2) == 1) ? RK_SER_TX : RK_SER_RX;
            route.line      = LINE_W'(off);
            route.fixed_reg = TGT_W'(TGT_REG_BASE + off);
        end else if (s >= TIMER_BASE && s < TIMER_BASE + NUM_TIMER) begin
            route.valid = 1'b1;
            route.kind  = RK_TIMER;
            route.line  = LINE_W'(off);
        end
    end
endmodule

// File: rtl/dmasel_cfgcheck.sv
module dmasel_cfgcheck
    import dmasel_pkg::*;
(
    input  route_t           route,
    input  logic [TGT_W-1:0] src,
    input  logic [TGT_W-1:0] dst,
    input  logic             burst,
    output logic             err
);
    always_comb begin
        unique case (route.kind)
            RK_SER_RX: err = (src != route.fixed_reg) || !tgt_permitted(dst) || burst;
            RK_SER_TX: err = (dst != route.fixed_reg) || !tgt_permitted(src) || burst;
            RK_TIMER:  err = !tgt_permitted(src) || !tgt_permitted(dst);
            default:   err = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmasel_reqedge.sv
module dmasel_reqedge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] en,
    output logic [N-1:0] gated,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic prev_q;
        assign gated[i] = req[i] & en[i];
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= gated[i];
        end
        assign rise[i] = gated[i] & ~prev_q;

        a_r2_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
            rise[i] |-> (en[i] && req[i]));
    end
endmodule

// File: rtl/dmasel_trigger.sv
module dmasel_trigger (
    input  logic clk,
    input  logic rst,
    input  logic allow,
    input  logic burst,
    input  logic rise,
    input  logic ack,
    input  logic tc_zero,
    input  logic clr_pend,
    output logic trig
);
    logic pend_q, trig_q;
    logic done, trig_d, pend_d;

    assign done = burst ? tc_zero : ack;

    always_comb begin
        if (trig_q) begin
            trig_d = !done;
            pend_d = pend_q | rise;
        end else begin
            trig_d = rise | pend_q;
            pend_d = rise & pend_q;
        end
        if (clr_pend) pend_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || !allow) begin
            trig_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            trig_q <= trig_d;
            pend_q <= pend_d;
        end
    end

    assign trig = trig_q;

    a_r8_hold_until_done: assert property (@(posedge clk) disable iff (rst)
        (trig_q && !done && allow) |=> trig_q);
    a_r8_release_on_done: assert property (@(posedge clk) disable iff (rst)
        (trig_q && done) |=> !trig_q);
    a_r9_pending_reissues: assert property (@(posedge clk) disable iff (rst)
        (!trig_q && pend_q && allow) |=> trig_q);
    a_r11_select_change_clears: assert property (@(posedge clk) disable iff (rst)
        clr_pend |=> !pend_q);
endmodule

// File: rtl/dma_req_select.sv
module dma_req_select
    import dmasel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 chan_en,
    input  logic [SEL_W-1:0]     res_sel,
    input  logic [TGT_W-1:0]     src_tgt,
    input  logic [TGT_W-1:0]     dst_tgt,
    input  logic                 burst_mode,
    input  logic [NUM_LINES-1:0] periph_req,
    input  logic [NUM_LINES-1:0] periph_irq_en,
    input  logic                 xfer_ack,
    input  logic                 count_zero,
    output logic [NUM_LINES-1:0] cpu_irq,
    output logic                 xfer_trig,
    output logic                 cfg_err
);
    route_t               route;
    logic [NUM_LINES-1:0] rise;
    logic [SEL_W-1:0]     sel_q;
    logic                 sel_chg, allow;

    dmasel_decode u_decode (.sel(res_sel), .route(route));

    dmasel_cfgcheck u_check (
        .route(route), .src(src_tgt), .dst(dst_tgt),
        .burst(burst_mode), .err(cfg_err)
    );

    dmasel_reqedge #(.N(NUM_LINES)) u_edge (
        .clk(clk), .rst(rst), .req(periph_req), .en(periph_irq_en),
        .gated(cpu_irq), .rise(rise)
    );

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= res_sel;
    end

    assign sel_chg = chan_en && (res_sel != sel_q);
    assign allow   = chan_en && route.valid && !cfg_err;

    dmasel_trigger u_trig (
        .clk(clk), .rst(rst), .allow(allow), .burst(burst_mode),
        .rise(rise[route.line]), .ack(xfer_ack), .tc_zero(count_zero),
        .clr_pend(sel_chg), .trig(xfer_trig)
    );

    a_r1_no_trig_without_route: assert property (@(posedge clk) disable iff (rst)
        !route.valid |=> !xfer_trig);
    a_r7_no_trig_when_blocked: assert property (@(posedge clk) disable iff (rst)
        (!chan_en || cfg_err) |=> !xfer_trig);
    a_r1_err_needs_route: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> route.valid);
endmodule

// File: tb/dma_req_select_tb_top.sv
module dma_req_select_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       chan_en;
    logic [3:0] res_sel, src_tgt, dst_tgt;
    logic       burst_mode;
    logic [7:0] periph_req, periph_irq_en;
    logic       xfer_ack, count_zero;
    logic [7:0] cpu_irq;
    logic       xfer_trig, cfg_err;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    always #5 clk = ~clk;

    dma_req_select dut_i (
        .clk(clk), .rst(rst), .chan_en(chan_en), .res_sel(res_sel),
        .src_tgt(src_tgt), .dst_tgt(dst_tgt), .burst_mode(burst_mode),
        .periph_req(periph_req), .periph_irq_en(periph_irq_en),
        .xfer_ack(xfer_ack), .count_zero(count_zero),
        .cpu_irq(cpu_irq), .xfer_trig(xfer_trig), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic bit perm(input int t);
        return (t <= 8) && (t != 4);
    endfunction

    function automatic bit exp_err(input int s, input int src, input int dst, input bit b);
        if (s >= 4 && s <= 7) begin
            int ch = (s - 4) / 2;
            if (s % 2 == 0) return (src != 5 + 2 * ch) || !perm(dst) || b;
            else            return (dst != 6 + 2 * ch) || !perm(src) || b;
        end
        if (s >= 8 && s <= 11) return !perm(src) || !perm(dst);
        return 1'b0;
    endfunction

    task automatic set_cfg(input int line, input bit b);
        res_sel    = 4'(line + 4);
        burst_mode = b;
        if (line < 4) begin
            if (line % 2 == 0) begin src_tgt = 4'(5 + line); dst_tgt = 4'd0; end
            else               begin src_tgt = 4'd2;         dst_tgt = 4'(5 + line); end
        end else begin
            src_tgt = 4'd1; dst_tgt = 4'd3;
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        rst = 1; chan_en = 0; res_sel = 0; src_tgt = 0; dst_tgt = 0; burst_mode = 0;
        periph_req = 0; periph_irq_en = 8'hFF; xfer_ack = 0; count_zero = 0;
        tick(); tick();
        check(xfer_trig == 0, "R8 reset trigger", int'(xfer_trig), 0);
        rst = 0;
        tick();

        // R3 R4 R5 R6 R1: full sweep of the error rule
        for (int s = 0; s < 16; s++)
            for (int a = 0; a < 16; a++)
                for (int d = 0; d < 16; d++)
                    for (int b = 0; b < 2; b++) begin
                        bit e;
                        res_sel = 4'(s); src_tgt = 4'(a); dst_tgt = 4'(d); burst_mode = b[0];
                        #1;
                        e = exp_err(s, a, d, b[0]);
                        check(cfg_err == e, "R3/R4/R5/R6 cfg_err", int'(cfg_err), int'(e));
                    end

        // R2: qualification of request lines
        for (int p = 0; p < 16; p++) begin
            periph_req    = 8'(p * 37 + 5);
            periph_irq_en = 8'(p * 91 + 3);
            #1;
            check(cpu_irq == (periph_req & periph_irq_en), "R2 cpu_irq",
                  int'(cpu_irq), int'(periph_req & periph_irq_en));
        end
        periph_req = 0; periph_irq_en = 8'hFF;
        tick();

        // R1 R8: each line, cycle-steal
        chan_en = 1;
        for (int i = 0; i < 8; i++) begin
            set_cfg(i, 0);
            tick(); tick();
            check(cfg_err == 0, "R1 valid cfg", int'(cfg_err), 0);
            periph_req = 8'(1 << i);
            tick();
            check(xfer_trig == 1, "R8 trigger raised", int'(xfer_trig), 1);
            tick(); tick();
            check(xfer_trig == 1, "R8 trigger held", int'(xfer_trig), 1);
            xfer_ack = 1;
            tick();
            xfer_ack = 0;
            check(xfer_trig == 0, "R8 trigger released", int'(xfer_trig), 0);
            tick();
            check(xfer_trig == 0, "R8 stays low", int'(xfer_trig), 0);
            periph_req = ~8'(1 << i);
            tick();
            check(xfer_trig == 0, "R1 other lines ignored", int'(xfer_trig), 0);
            periph_req = 0;
            tick();
        end

        // R2: disabled line does not trigger
        set_cfg(4, 0);
        periph_irq_en = 8'hEF;
        tick();
        periph_req = 8'h10;
        tick(); tick();
        check(xfer_trig == 0, "R2 gated line", int'(xfer_trig), 0);
        periph_req = 0; periph_irq_en = 8'hFF;
        tick();

        // R9: remembered request
        periph_req = 8'h10;
        tick();
        check(xfer_trig == 1, "R9 first trigger", int'(xfer_trig), 1);
        periph_req = 0; tick();
        periph_req = 8'h10; tick();
        xfer_ack = 1; tick(); xfer_ack = 0;
        check(xfer_trig == 0, "R9 gap cycle", int'(xfer_trig), 0);
        tick();
        check(xfer_trig == 1, "R9 reissued", int'(xfer_trig), 1);
        xfer_ack = 1; tick(); xfer_ack = 0;
        tick();
        check(xfer_trig == 0, "R9 single reissue", int'(xfer_trig), 0);
        periph_req = 0; tick();

        // R11: select change discards remembered request
        periph_req = 8'h10; tick();
        periph_req = 0; tick();
        periph_req = 8'h10; tick();
        set_cfg(5, 0); tick();
        set_cfg(4, 0); tick();
        check(xfer_trig == 1, "R11 current trigger kept", int'(xfer_trig), 1);
        xfer_ack = 1; tick(); xfer_ack = 0;
        tick(); tick();
        check(xfer_trig == 0, "R11 pending discarded", int'(xfer_trig), 0);
        periph_req = 0; tick();

        // R10: burst mode
        set_cfg(6, 1); tick();
        periph_req = 8'h40; tick();
        check(xfer_trig == 1, "R10 burst start", int'(xfer_trig), 1);
        xfer_ack = 1; tick(); tick(); xfer_ack = 0;
        check(xfer_trig == 1, "R10 ack ignored", int'(xfer_trig), 1);
        count_zero = 1; tick(); count_zero = 0;
        check(xfer_trig == 0, "R10 count zero ends", int'(xfer_trig), 0);
        periph_req = 0; tick();

        // R7: error config and disabled channel
        set_cfg(1, 1); tick();
        check(cfg_err == 1, "R6 serial burst error", int'(cfg_err), 1);
        periph_req = 8'h02; tick(); tick();
        check(xfer_trig == 0, "R7 no trigger on error", int'(xfer_trig), 0);
        periph_req = 0; set_cfg(7, 0); chan_en = 0; tick();
        periph_req = 8'h80; tick(); tick();
        check(xfer_trig == 0, "R7 no trigger when disabled", int'(xfer_trig), 0);
        periph_req = 0; chan_en = 1; tick();

        // R7: trigger dropped when channel disabled mid-transfer
        periph_req = 8'h80; tick();
        check(xfer_trig == 1, "R7 trigger before disable", int'(xfer_trig), 1);
        chan_en = 0; tick();
        check(xfer_trig == 0, "R7 dropped on disable", int'(xfer_trig), 0);
        chan_en = 1; periph_req = 0; tick();

        // R1: unused select codes
        res_sel = 4'd0; src_tgt = 0; dst_tgt = 0; tick();
        periph_req = 8'hFF; tick(); tick();
        check(xfer_trig == 0, "R1 code 0 no trigger", int'(xfer_trig), 0);
        check(cfg_err == 0, "R1 code 0 no error", int'(cfg_err), 0);
        periph_req = 0; res_sel = 4'd12; tick();
        periph_req = 8'hFF; tick(); tick();
        check(xfer_trig == 0, "R1 code 12 no trigger", int'(xfer_trig), 0);
        periph_req = 0; tick();

        finish_run();
    end
endmodule